// File: doc/BRIEF.md
# Free Address Stack Cache

This block keeps a short on-chip last-in-first-out store of free cell addresses. It sits in front of a free list that lives in a slower external pointer memory. Released addresses go onto the on-chip store, and allocation requests take the address on top of it. While the store has neither too many nor too few entries, allocation and release touch the pointer memory not at all.

When the store holds at least `AFULL_LVL` addresses, it moves one address at a time into the external list through a pointer-memory write. The external list works as a stack: a spilled address r becomes the new external head, and pointer[r] receives the old head. When the store holds no more than `REFILL_LVL` addresses, it reads pointer[head] to take the head address out of the external list. The head address is then pushed, or handed straight to a waiting allocation, and the word read becomes the new head.

The pointer memory is reached through a single-outstanding request/acknowledge port. After reset the external list is assumed to hold every cell, with head 0 and pointer[i] = i+1. The owner of the memory prepares that content.

Top module: `free_addr_cache`

## Requirements
- R1: A release accepted while the block is idle toward memory, with no allocation and occupancy below `AFULL_LVL`, raises `occ` by one and starts no pointer-memory request.
- R2: An allocation while `occ` is non-zero is accepted at once and returns the most recently stored address (last in, first out).
- R3: A release and an allocation presented together while `occ` is 0 hand the released address straight to the allocator (`alloc_addr` = `rel_addr`), and `occ` stays 0.
- R4: When `occ` is at least `AFULL_LVL` in an idle cycle with no allocation, one address r leaves the store. The block issues a write with `pm_we`=1, `pm_addr`=r and `pm_wdata`= the old external head, and r becomes the head. This repeats while `occ` stays at or above the level.
- R5: When `occ` is at most `REFILL_LVL` and the external list is not empty, the block issues a read with `pm_we`=0 at the head. On the acknowledge, the head address is stored or allocated, `pm_rdata` becomes the new head, and `ext_cnt` falls by one.
- R6: With `occ` 0, no release offered and no read acknowledge, `alloc_rdy` is low and the allocation stalls.
- R7: `rel_rdy` is low when `occ` equals `DEPTH`, and also when `occ` equals `DEPTH`-1 while a refill read is pending. `occ` never exceeds `DEPTH`.
- R8: `ext_empty` is high exactly when `ext_cnt` is 0, and no refill read is issued then.
- R9: `occ` + `ext_cnt` + the number of addresses held by users always equals `N_CELLS`. An address whose spill is in flight is already counted in `ext_cnt`.
- R10: During reset, `occ` is 0, `ext_cnt` equals `N_CELLS`, and `pm_req` and `alloc_rdy` are low.
- R11: A pointer-memory request keeps `pm_req`, `pm_we`, `pm_addr` and `pm_wdata` unchanged until `pm_ack`. `pm_ack` is a one-cycle pulse that carries `pm_rdata` for reads.
- R12: From reset, successive allocations return cells 0, 1, 2, … in external-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocation requested |
| alloc_rdy | output | 1 | An address is available this cycle |
| alloc_addr | output | ADDR_W | Address handed out when req and rdy are both high |
| rel_valid | input | 1 | An address is being released |
| rel_rdy | output | 1 | Release can be taken this cycle |
| rel_addr | input | ADDR_W | Released address |
| pm_req | output | 1 | Pointer-memory request pending |
| pm_we | output | 1 | 1 = write (spill), 0 = read (refill) |
| pm_addr | output | ADDR_W | Pointer-memory word address |
| pm_wdata | output | ADDR_W | Next-pointer written on a spill |
| pm_ack | input | 1 | One-cycle request completion |
| pm_rdata | input | ADDR_W | Next-pointer read, valid with pm_ack |
| occ | output | OCC_W | On-chip store occupancy |
| ext_cnt | output | EXT_W | Addresses in the external list |
| ext_empty | output | 1 | External list exhausted |

## Verification
The bench builds the block with `N_CELLS`=16, `DEPTH`=4, `AFULL_LVL`=3 and `REFILL_LVL`=0. With these values, sixteen allocations exhaust the pool and three releases reach the spill level. Every allocation on an empty store forces a refill, so the external list order can be read back directly through allocation. The memory model's latency can be raised to 20 cycles, which keeps a spill in flight long enough for releases to fill the store to its full depth.

// File: rtl/free_addr_cache_pkg.sv
package free_addr_cache_pkg;

    // Pointer-memory activity of the cache controller
    typedef enum logic [1:0] {
        FC_IDLE  = 2'd0,
        FC_SPILL = 2'd1,
        FC_FILL  = 2'd2
    } fc_state_e;

endpackage

// File: rtl/free_addr_lifo.sv
// Register stack with one pop and two pushes per cycle.
// The pop is applied first, then push_a, then push_b.
module free_addr_lifo #(
    parameter  int DEPTH  = 8,
    parameter  int ADDR_W = 6,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push_a,
    input  logic [ADDR_W-1:0] data_a,
    input  logic              push_b,
    input  logic [ADDR_W-1:0] data_b,
    output logic [ADDR_W-1:0] top,
    output logic [OCC_W-1:0]  occ
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] slot;
        logic [OCC_W-1:0]             occ;
    } lifo_t;

    lifo_t            s_d, s_q;
    logic [OCC_W-1:0] base;

    always_comb begin
        s_d  = s_q;
        base = s_q.occ - OCC_W'(pop);
        if (push_a) s_d.slot[IDX_W'(base)] = data_a;
        if (push_b) s_d.slot[IDX_W'(base + OCC_W'(push_a))] = data_b;
        s_d.occ = base + OCC_W'(push_a) + OCC_W'(push_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign top = s_q.slot[IDX_W'(s_q.occ - OCC_W'(1))];
    assign occ = s_q.occ;

endmodule

// File: rtl/free_addr_cache.sv
module free_addr_cache
    import free_addr_cache_pkg::*;
#(
    parameter  int N_CELLS    = 64,
    parameter  int DEPTH      = 8,
    parameter  int AFULL_LVL  = 6,
    parameter  int REFILL_LVL = 0,
    localparam int ADDR_W     = $clog2(N_CELLS),
    localparam int OCC_W      = $clog2(DEPTH + 1),
    localparam int EXT_W      = $clog2(N_CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              alloc_rdy,
    output logic [ADDR_W-1:0] alloc_addr,
    input  logic              rel_valid,
    output logic              rel_rdy,
    input  logic [ADDR_W-1:0] rel_addr,
    output logic              pm_req,
    output logic              pm_we,
    output logic [ADDR_W-1:0] pm_addr,
    output logic [ADDR_W-1:0] pm_wdata,
    input  logic              pm_ack,
    input  logic [ADDR_W-1:0] pm_rdata,
    output logic [OCC_W-1:0]  occ,
    output logic [EXT_W-1:0]  ext_cnt,
    output logic              ext_empty
);

    localparam logic [OCC_W-1:0] AFULL_V  = OCC_W'(AFULL_LVL);
    localparam logic [OCC_W-1:0] REFILL_V = OCC_W'(REFILL_LVL);
    localparam logic [OCC_W-1:0] DEPTH_V  = OCC_W'(DEPTH);
    localparam logic [EXT_W-1:0] POOL_V   = EXT_W'(N_CELLS);

    typedef struct packed {
        fc_state_e         st;
        logic [ADDR_W-1:0] head;
        logic [ADDR_W-1:0] spill_addr;
        logic [EXT_W-1:0]  ext_cnt;
    } ctl_t;

    ctl_t              c_d, c_q;
    logic [ADDR_W-1:0] stk_top;
    logic [OCC_W-1:0]  stk_occ;
    logic              stk_has, fill_ack, spill_ack;
    logic              rel_fire, alloc_fire, spill_go, fill_go;
    logic              lifo_pop, push_rel, push_fill;

    free_addr_lifo #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_lifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (lifo_pop),
        .push_a (push_rel),
        .data_a (rel_addr),
        .push_b (push_fill),
        .data_b (c_q.head),
        .top    (stk_top),
        .occ    (stk_occ)
    );

    always_comb begin
        stk_has   = (stk_occ != '0);
        fill_ack  = (c_q.st == FC_FILL)  && pm_ack;
        spill_ack = (c_q.st == FC_SPILL) && pm_ack;

        // One slot is kept for the head address while a refill is pending
        rel_rdy  = stk_occ < ((c_q.st == FC_FILL) ? DEPTH_V - OCC_W'(1) : DEPTH_V);
        rel_fire = rel_valid && rel_rdy;

        // Source order: stack top, then release bypass, then refill bypass
        alloc_rdy  = stk_has || rel_valid || fill_ack;
        alloc_addr = stk_has ? stk_top : (rel_valid ? rel_addr : c_q.head);
        alloc_fire = alloc_req && alloc_rdy;

        spill_go = (c_q.st == FC_IDLE) && (stk_occ >= AFULL_V) && !alloc_fire;
        fill_go  = (c_q.st == FC_IDLE) && !spill_go && (stk_occ <= REFILL_V)
                   && (c_q.ext_cnt != '0);

        // A release arriving in a spill launch cycle is spilled directly
        lifo_pop  = (alloc_fire && stk_has) || (spill_go && !rel_fire);
        push_rel  = rel_fire && !(alloc_fire && !stk_has) && !spill_go;
        push_fill = fill_ack && !(alloc_fire && !stk_has && !rel_valid);

        c_d = c_q;
        if (spill_go) begin
            c_d.st         = FC_SPILL;
            c_d.spill_addr = rel_fire ? rel_addr : stk_top;
            c_d.ext_cnt    = c_q.ext_cnt + EXT_W'(1);
        end else if (fill_go) begin
            c_d.st = FC_FILL;
        end
        if (spill_ack) begin
            c_d.st   = FC_IDLE;
            c_d.head = c_q.spill_addr;
        end
        if (fill_ack) begin
            c_d.st      = FC_IDLE;
            c_d.head    = pm_rdata;
            c_d.ext_cnt = c_q.ext_cnt - EXT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st         <= FC_IDLE;
            c_q.head       <= '0;
            c_q.spill_addr <= '0;
            c_q.ext_cnt    <= POOL_V;
        end else begin
            c_q <= c_d;
        end
    end

    assign pm_req    = (c_q.st != FC_IDLE);
    assign pm_we     = (c_q.st == FC_SPILL);
    assign pm_addr   = (c_q.st == FC_SPILL) ? c_q.spill_addr : c_q.head;
    assign pm_wdata  = c_q.head;
    assign occ       = stk_occ;
    assign ext_cnt   = c_q.ext_cnt;
    assign ext_empty = (c_q.ext_cnt == '0);

endmodule

// File: rtl/free_addr_cache_chk.sv
module free_addr_cache_chk #(
    parameter int DEPTH     = 8,
    parameter int AFULL_LVL = 6,
    parameter int ADDR_W    = 6,
    parameter int OCC_W     = 4,
    parameter int EXT_W     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              alloc_rdy,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic              rel_valid,
    input logic              rel_rdy,
    input logic [ADDR_W-1:0] rel_addr,
    input logic              pm_req,
    input logic              pm_we,
    input logic [ADDR_W-1:0] pm_addr,
    input logic [ADDR_W-1:0] pm_wdata,
    input logic              pm_ack,
    input logic [OCC_W-1:0]  occ,
    input logic [EXT_W-1:0]  ext_cnt,
    input logic              ext_empty
);

    localparam logic [OCC_W-1:0] DEPTH_V = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] AFULL_V = OCC_W'(AFULL_LVL);

    p_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && rel_rdy && !alloc_req && !pm_req && occ < AFULL_V
        |=> occ == $past(occ) + OCC_W'(1));

    p_pop_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && occ != '0 |-> alloc_rdy);

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && rel_valid && occ == '0 |-> alloc_rdy && alloc_addr == rel_addr);

    p_refill_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req && !pm_we && pm_ack |=> ext_cnt == $past(ext_cnt) - EXT_W'(1));

    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        occ == '0 && !rel_valid && !pm_ack |-> !alloc_rdy);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);

    p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ == DEPTH_V |-> !rel_rdy);

    p_no_read_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req && !pm_we |-> !ext_empty);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pm_req && !pm_ack |=> pm_req && $stable(pm_addr) && $stable(pm_we)
                              && $stable(pm_wdata));

endmodule

bind free_addr_cache free_addr_cache_chk #(
    .DEPTH     (DEPTH),
    .AFULL_LVL (AFULL_LVL),
    .ADDR_W    (ADDR_W),
    .OCC_W     (OCC_W),
    .EXT_W     (EXT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .alloc_rdy  (alloc_rdy),
    .alloc_addr (alloc_addr),
    .rel_valid  (rel_valid),
    .rel_rdy    (rel_rdy),
    .rel_addr   (rel_addr),
    .pm_req     (pm_req),
    .pm_we      (pm_we),
    .pm_addr    (pm_addr),
    .pm_wdata   (pm_wdata),
    .pm_ack     (pm_ack),
    .occ        (occ),
    .ext_cnt    (ext_cnt),
    .ext_empty  (ext_empty)
);

// File: tb/free_addr_cache_bench.sv
module free_addr_cache_bench;

    localparam int NC = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alloc_req, alloc_rdy, rel_valid, rel_rdy;
    logic [3:0] alloc_addr, rel_addr;
    logic       pm_req, pm_we, pm_ack;
    logic [3:0] pm_addr, pm_wdata, pm_rdata;
    logic [2:0] occ;
    logic [4:0] ext_cnt;
    logic       ext_empty;

    int checks = 0;
    int errors = 0;
    int held   = 0;
    int lat    = 3;
    int pm_ops = 0;
    int hold_err = 0;
    int wcnt   = 0;
    logic [3:0] mem [NC];
    logic [3:0] last_wa, last_wd, sv_addr, sv_wd;
    logic       sv_we;

    always #2 clk = ~clk;

    free_addr_cache #(
        .N_CELLS    (NC),
        .DEPTH      (4),
        .AFULL_LVL  (3),
        .REFILL_LVL (0)
    ) u_free_addr_cache (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_rdy(alloc_rdy), .alloc_addr(alloc_addr),
        .rel_valid(rel_valid), .rel_rdy(rel_rdy), .rel_addr(rel_addr),
        .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .pm_ack(pm_ack), .pm_rdata(pm_rdata),
        .occ(occ), .ext_cnt(ext_cnt), .ext_empty(ext_empty)
    );

    // Pointer memory model: fixed latency, one-cycle acknowledge
    initial begin
        pm_ack = 1'b0;
        pm_rdata = '0;
        last_wa = '0;
        last_wd = '0;
        for (int i = 0; i < NC; i++) mem[i] = 4'(i + 1);
        forever begin
            @(negedge clk);
            if (pm_ack) begin
                pm_ack = 1'b0;
                wcnt = 0;
            end else if (pm_req) begin
                if (wcnt == 0) begin
                    pm_ops++;
                    sv_addr = pm_addr; sv_we = pm_we; sv_wd = pm_wdata;
                end else if (pm_addr != sv_addr || pm_we != sv_we || pm_wdata != sv_wd) begin
                    hold_err++;
                end
                if (wcnt >= lat - 1) begin
                    pm_ack = 1'b1;
                    pm_rdata = mem[pm_addr];
                    if (pm_we) begin
                        mem[pm_addr] = pm_wdata;
                        last_wa = pm_addr;
                        last_wd = pm_wdata;
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_alloc(input string tag, input int exp);
        @(negedge clk);
        alloc_req = 1'b1;
        #1;
        while (!alloc_rdy) begin
            @(negedge clk);
            #1;
        end
        chk(tag, alloc_addr, exp);
        held++;
        @(negedge clk);
        alloc_req = 1'b0;
    endtask

    task automatic do_release(input int a);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_addr  = 4'(a);
        #1;
        while (!rel_rdy) begin
            @(negedge clk);
            #1;
        end
        held--;
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic chk_conserve(input string tag);
        chk(tag, int'(occ) + int'(ext_cnt) + held, NC);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        alloc_req = 1'b0;
        rel_valid = 1'b0;
        rel_addr  = '0;
        wait_cycles(3);
        #1;
        chk("R10 reset occ", occ, 0);
        chk("R10 reset ext_cnt", ext_cnt, NC);
        chk("R10 reset pm_req", pm_req, 0);
        chk("R10 reset alloc_rdy", alloc_rdy, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_drain_pool;
        for (int i = 0; i < NC; i++) do_alloc("R12 R5 initial list order", i);
        wait_cycles(6);
        chk("R8 ext_empty after drain", ext_empty, 1);
        chk("R5 ext_cnt after drain", ext_cnt, 0);
        chk_conserve("R9 after drain");
    endtask

    task automatic t_exhausted;
        int ops0 = pm_ops;
        @(negedge clk);
        alloc_req = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk("R6 stall with empty stack", alloc_rdy, 0);
            @(negedge clk);
        end
        alloc_req = 1'b0;
        chk("R8 no refill while exhausted", pm_ops, ops0);
    endtask

    task automatic t_lifo;
        int ops0 = pm_ops;
        do_release(5);
        #1;
        chk("R1 occ after one release", occ, 1);
        do_release(9);
        #1;
        chk("R1 occ after two releases", occ, 2);
        do_alloc("R2 last in first out", 9);
        do_alloc("R2 older entry second", 5);
        wait_cycles(4);
        chk("R1 no memory access", pm_ops, ops0);
        chk("R2 occ after pops", occ, 0);
    endtask

    task automatic t_bypass;
        int ops0 = pm_ops;
        @(negedge clk);
        alloc_req = 1'b1;
        rel_valid = 1'b1;
        rel_addr  = 4'd7;
        #1;
        chk("R3 bypass ready", alloc_rdy, 1);
        chk("R3 bypass address", alloc_addr, 7);
        @(negedge clk);
        alloc_req = 1'b0;
        rel_valid = 1'b0;
        wait_cycles(3);
        chk("R3 occ stays zero", occ, 0);
        chk("R3 no memory access", pm_ops, ops0);
        chk_conserve("R9 after bypass");
    endtask

    task automatic t_spill_refill;
        do_release(1);
        do_release(2);
        do_release(3);
        wait_cycles(10);
        chk("R4 occ after spill", occ, 2);
        chk("R4 ext_cnt after spill", ext_cnt, 1);
        chk("R4 spill write address", last_wa, 3);
        chk("R4 spill write links old head", last_wd, 0);
        do_alloc("R2 top after spill", 2);
        do_alloc("R2 next after spill", 1);
        do_alloc("R5 refill returns spilled cell", 3);
        wait_cycles(6);
        chk("R5 ext_cnt after refill", ext_cnt, 0);
        chk_conserve("R9 after spill and refill");
    endtask

    task automatic t_spill_chain;
        int ops0;
        int got;
        do_release(4);
        do_release(5);
        do_release(6);
        wait_cycles(10);
        do_release(8);
        wait_cycles(10);
        chk("R4 second spill address", last_wa, 8);
        chk("R4 second spill links first", last_wd, 6);
        chk("R4 ext_cnt after two spills", ext_cnt, 2);
        chk("R4 occ after two spills", occ, 2);
        ops0 = pm_ops;
        @(negedge clk);
        alloc_req = 1'b1;
        rel_valid = 1'b1;
        rel_addr  = 4'd10;
        #1;
        got = alloc_addr;
        chk("R2 concurrent alloc takes top", got, 5);
        @(negedge clk);
        alloc_req = 1'b0;
        rel_valid = 1'b0;
        wait_cycles(3);
        chk("R2 occ unchanged by pair", occ, 2);
        chk("R1 pair needs no memory access", pm_ops, ops0);
        do_alloc("R2 release pushed on top", 10);
        do_alloc("R2 bottom entry", 4);
        do_alloc("R5 refill head first", 8);
        do_alloc("R5 refill follows link", 6);
        wait_cycles(6);
        chk("R8 exhausted again", ext_empty, 1);
        chk_conserve("R9 after chain");
    endtask

    task automatic t_full;
        lat = 20;
        do_release(11);
        do_release(12);
        do_release(13);
        wait_cycles(2);
        do_release(14);
        do_release(15);
        #1;
        chk("R7 occ reaches depth", occ, 4);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_addr  = 4'd0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R7 release refused when full", rel_rdy, 0);
            @(negedge clk);
        end
        rel_valid = 1'b0;
        lat = 3;
        wait_cycles(80);
        chk("R4 spill down below level", occ, 2);
        chk("R4 ext_cnt after spills", ext_cnt, 3);
        chk("R4 last spill", last_wa, 14);
        chk("R4 last spill link", last_wd, 15);
        chk_conserve("R9 after full");
        do_alloc("R2 stack top", 12);
        do_alloc("R2 stack bottom", 11);
        do_alloc("R5 list head", 14);
        do_alloc("R5 list second", 15);
        do_alloc("R5 list third", 13);
        wait_cycles(6);
        chk_conserve("R9 at end");
        chk("R11 request held until ack", hold_err, 0);
    endtask

    initial begin
        t_reset();
        t_drain_pool();
        t_exhausted();
        t_lifo();
        t_bypass();
        t_spill_refill();
        t_spill_chain();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule